// File: doc/BRIEF.md
# Accelerator Control Register Block

This block holds the host-visible control registers of a compute accelerator. It models only the register behaviour and does no compute work. The host uses a simple 32-bit register bus to write a command register, to write power-on and power-off requests for four power domains (shader, tiler, L2, L3), and to use an interrupt group. That group has a raw status word, a clear word, a mask word and a masked status word. A single level interrupt line goes back to the host.

Each domain has a fixed 64-bit present mask, set by parameter, and a 64-bit ready mask. Both are split into a low and a high 32-bit word. A power-on request marks units ready only where they are present. A power-off request drops units from the ready mask. Each power request raises two power-change interrupt bits. Commands are numbered. Some raise their own completion interrupt. Two of them reset the block state and send a one-cycle reset request to the rest of the device.

Writes take effect on the clock edge that samples them. Reads have one cycle of latency: `rd_data` is valid in the cycle after `rd_en`.

Top module: `accel_ctrl_regs`

## Requirements
- R1: After `rst`, every ready word, the raw status word and the mask word read as zero, and `irq` and `reset_pulse` are low.
- R2: A write to a domain's power-on word (offset 4 for the low half, offset 5 for the high half, within its 8-word group) ORs the written value, ANDed with that domain's present half, into the matching ready half. The groups start at word address 0x10 for shader, 0x18 for tiler, 0x20 for L2 and 0x28 for L3.
- R3: A write to a domain's power-off word (offset 6 for the low half, offset 7 for the high half) clears, in the matching ready half, each bit that is 1 in the written value.
- R4: Every power-on or power-off write sets raw status bits 1 and 2, even when no ready bit changes.
- R5: Writing 1 (soft reset) or 2 (hard reset) to the command word (address 0x00) clears all ready words and the mask word, and leaves the raw status word equal to 0x1 (bit 0, reset done). It also drives `reset_pulse` high for the one cycle that follows the write edge.
- R6: Command 4 sets raw status bit 3 (sample done). Commands 7 and 8 set raw status bit 4 (cache clean done).
- R7: Commands 0, 3, 5 and 6, and any command value of 9 or higher, change no state and raise no interrupt.
- R8: A write to the clear word (address 0x02) clears the raw status bits that are 1 in the written value.
- R9: The status word (address 0x04) reads raw status AND mask (mask at address 0x03, 5 bits). `irq` is high in the cycle after the status word becomes nonzero, and low in the cycle after it becomes zero.
- R10: Writes to the present words, ready words, raw status word (address 0x01), status word, or any unmapped address change no state.
- R11: A read returns its data one cycle after `rd_en`. Present words return the parameter values, power-request words and unmapped addresses return zero, and raw status is at address 0x01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Write word address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | AW | Read word address |
| rd_data | output | 32 | Read data, one cycle after rd_en |
| irq | output | 1 | Level interrupt to the host |
| reset_pulse | output | 1 | One-cycle reset request to the device |

## Verification
The hardest case to reach from the ports is a reset command that arrives while the block is busy. At that moment ready bits are set, pending interrupts are set and the mask is armed. A correct reset must wipe all of that and still leave exactly the reset-done bit pending.

To reach that case, the stimulus first powers up units, then arms the mask, then issues each reset command. It reads back every affected word and watches the one-cycle pulse and the interrupt line. Power requests to a domain with no units present are also used. They prove that the interrupt bits are raised even when no ready bit moves.

// File: rtl/accel_ctrl_pkg.sv
package accel_ctrl_pkg;
  localparam int IRQ_W = 5;

  // interrupt bit positions
  localparam int IRQ_RST_DONE   = 0;
  localparam int IRQ_PWR_ONE    = 1;
  localparam int IRQ_PWR_ALL    = 2;
  localparam int IRQ_SAMPLE     = 3;
  localparam int IRQ_CLEAN      = 4;

  // word addresses of the control group
  localparam int A_CMD   = 0;
  localparam int A_RAW   = 1;
  localparam int A_CLR   = 2;
  localparam int A_MASK  = 3;
  localparam int A_STAT  = 4;

  // domain groups: 8 words each, first group at block index 2 (0x10)
  localparam int DOM_BLK0 = 2;

  typedef enum logic [2:0] {
    SUB_PRES_LO = 3'd0, SUB_PRES_HI = 3'd1,
    SUB_RDY_LO  = 3'd2, SUB_RDY_HI  = 3'd3,
    SUB_ON_LO   = 3'd4, SUB_ON_HI   = 3'd5,
    SUB_OFF_LO  = 3'd6, SUB_OFF_HI  = 3'd7
  } dom_sub_e;

  typedef enum logic [3:0] {
    OP_NOP = 4'd0, OP_SOFT_RST = 4'd1, OP_HARD_RST = 4'd2,
    OP_CNT_CLR = 4'd3, OP_CNT_SAMPLE = 4'd4, OP_CYC_START = 4'd5,
    OP_CYC_STOP = 4'd6, OP_CLEAN = 4'd7, OP_CLEAN_INV = 4'd8
  } op_e;
  localparam int OP_COUNT = 9;
endpackage

// File: rtl/accel_cmd_decode.sv
module accel_cmd_decode
  import accel_ctrl_pkg::*;
#(
  parameter int DW = 32
)(
  input  logic              cmd_we,
  input  logic [DW-1:0]     cmd_val,
  output logic [IRQ_W-1:0]  cmd_irq,
  output logic              dev_reset
);
  logic in_range;
  op_e  op;

  assign in_range = cmd_we && (cmd_val < DW'(OP_COUNT));
  assign op       = op_e'(cmd_val[3:0]);

  always_comb begin
    cmd_irq   = '0;
    dev_reset = 1'b0;
    if (in_range) begin
      unique case (op)
        OP_SOFT_RST, OP_HARD_RST: begin
          dev_reset             = 1'b1;
          cmd_irq[IRQ_RST_DONE] = 1'b1;
        end
        OP_CNT_SAMPLE:          cmd_irq[IRQ_SAMPLE] = 1'b1;
        OP_CLEAN, OP_CLEAN_INV: cmd_irq[IRQ_CLEAN]  = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/accel_pwr_domain.sv
module accel_pwr_domain
  import accel_ctrl_pkg::*;
#(
  parameter int          AW      = 6,
  parameter int          DW      = 32,
  parameter int          IDX     = 0,
  parameter logic [63:0] PRESENT = 64'h0
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          dev_reset,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic [63:0]   ready,
  output logic          pwr_evt
);
  logic     hit;
  dom_sub_e sub;
  logic [DW-1:0] rdy_lo, rdy_hi;

  assign hit = wr_en && (int'(wr_addr[AW-1:3]) == DOM_BLK0 + IDX);
  assign sub = dom_sub_e'(wr_addr[2:0]);

  always_ff @(posedge clk) begin
    if (rst || dev_reset) begin
      rdy_lo <= '0;
      rdy_hi <= '0;
    end else if (hit) begin
      case (sub)
        SUB_ON_LO:  rdy_lo <= rdy_lo | (wr_data & PRESENT[31:0]);
        SUB_ON_HI:  rdy_hi <= rdy_hi | (wr_data & PRESENT[63:32]);
        SUB_OFF_LO: rdy_lo <= rdy_lo & ~wr_data;
        SUB_OFF_HI: rdy_hi <= rdy_hi & ~wr_data;
        default: ;
      endcase
    end
  end

  assign ready   = {rdy_hi, rdy_lo};
  assign pwr_evt = hit && wr_addr[2];

  assert_on_lo_R2: assert property (@(posedge clk) disable iff (rst)
    (hit && sub == SUB_ON_LO && !dev_reset) |=>
      ((rdy_lo & $past(wr_data & PRESENT[31:0])) == $past(wr_data & PRESENT[31:0])));
  assert_off_lo_R3: assert property (@(posedge clk) disable iff (rst)
    (hit && sub == SUB_OFF_LO && !dev_reset) |=> ((rdy_lo & $past(wr_data)) == '0));
  assert_off_hi_R3: assert property (@(posedge clk) disable iff (rst)
    (hit && sub == SUB_OFF_HI && !dev_reset) |=> ((rdy_hi & $past(wr_data)) == '0));
endmodule

// File: rtl/accel_irq_unit.sv
module accel_irq_unit
  import accel_ctrl_pkg::*;
#(
  parameter int AW = 6
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             dev_reset,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [IRQ_W-1:0] wr_bits,
  input  logic [IRQ_W-1:0] set_bits,
  output logic [IRQ_W-1:0] raw,
  output logic [IRQ_W-1:0] mask,
  output logic             irq
);
  logic [IRQ_W-1:0] clr_bits;

  assign clr_bits = (wr_en && int'(wr_addr) == A_CLR) ? wr_bits : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      raw  <= '0;
      mask <= '0;
      irq  <= 1'b0;
    end else begin
      irq <= |(raw & mask);
      if (dev_reset) begin
        raw  <= set_bits;
        mask <= '0;
      end else begin
        raw <= (raw & ~clr_bits) | set_bits;
        if (wr_en && int'(wr_addr) == A_MASK) mask <= wr_bits;
      end
    end
  end

  assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (|clr_bits && !dev_reset) |=> ((raw & $past(clr_bits & ~set_bits)) == '0));
  assert_pwr_pair_R4: assert property (@(posedge clk) disable iff (rst)
    set_bits[IRQ_PWR_ONE] |=> (raw[IRQ_PWR_ONE] && raw[IRQ_PWR_ALL]));
  assert_irq_level_R9: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|(raw & mask)));
endmodule

// File: rtl/accel_ctrl_regs.sv
module accel_ctrl_regs
  import accel_ctrl_pkg::*;
#(
  parameter int                  AW      = 6,
  parameter int                  DW      = 32,
  parameter int                  NDOM    = 4,
  parameter logic [NDOM-1:0][63:0] PRESENT = {64'h0, 64'h3, 64'h1, 64'h0000_000F_0000_00FF}
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          irq,
  output logic          reset_pulse
);
  localparam int TOP_WORD = (DOM_BLK0 + NDOM) * 8;

  logic [IRQ_W-1:0] cmd_irq, set_bits, raw, mask;
  logic             dev_reset, any_pwr;
  logic [NDOM-1:0]  pwr_evt;
  logic [NDOM-1:0][63:0] ready;
  logic [DW-1:0]    rd_next;

  accel_cmd_decode #(.DW(DW)) u_dec (
    .cmd_we   (wr_en && int'(wr_addr) == A_CMD),
    .cmd_val  (wr_data),
    .cmd_irq  (cmd_irq),
    .dev_reset(dev_reset)
  );

  for (genvar d = 0; d < NDOM; d++) begin : g_dom
    accel_pwr_domain #(.AW(AW), .DW(DW), .IDX(d), .PRESENT(PRESENT[d])) u_dom (
      .clk(clk), .rst(rst), .dev_reset(dev_reset),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .ready(ready[d]), .pwr_evt(pwr_evt[d])
    );
  end

  assign any_pwr  = |pwr_evt;
  assign set_bits = cmd_irq | (any_pwr ? IRQ_W'((1 << IRQ_PWR_ONE) | (1 << IRQ_PWR_ALL)) : '0);

  accel_irq_unit #(.AW(AW)) u_irq (
    .clk(clk), .rst(rst), .dev_reset(dev_reset),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_bits(wr_data[IRQ_W-1:0]),
    .set_bits(set_bits), .raw(raw), .mask(mask), .irq(irq)
  );

  always_comb begin
    rd_next = '0;
    if (int'(rd_addr) == A_RAW)  rd_next = DW'(raw);
    if (int'(rd_addr) == A_MASK) rd_next = DW'(mask);
    if (int'(rd_addr) == A_STAT) rd_next = DW'(raw & mask);
    for (int d = 0; d < NDOM; d++) begin
      if (int'(rd_addr[AW-1:3]) == DOM_BLK0 + d) begin
        case (dom_sub_e'(rd_addr[2:0]))
          SUB_PRES_LO: rd_next = PRESENT[d][31:0];
          SUB_PRES_HI: rd_next = PRESENT[d][63:32];
          SUB_RDY_LO:  rd_next = ready[d][31:0];
          SUB_RDY_HI:  rd_next = ready[d][63:32];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data     <= '0;
      reset_pulse <= 1'b0;
    end else begin
      reset_pulse <= dev_reset;
      if (rd_en) rd_data <= rd_next;
    end
  end

  initial assert (TOP_WORD <= (1 << AW)) else $error("address width too small for domains");

  assert_reset_raw_R5: assert property (@(posedge clk) disable iff (rst)
    reset_pulse |-> (raw == IRQ_W'(1 << IRQ_RST_DONE) && mask == '0));
  assert_reset_ready_R5: assert property (@(posedge clk) disable iff (rst)
    reset_pulse |-> (ready == '0));
endmodule

// File: tb/accel_ctrl_regs_bench.sv
`timescale 1ns/1ps
module accel_ctrl_regs_bench;
  localparam int AW = 6;
  localparam int DW = 32;
  localparam logic [3:0][63:0] PRES = {64'h0, 64'h3, 64'h1, 64'h0000_000F_0000_00FF};

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic irq, reset_pulse;

  int compared = 0, mismatched = 0;
  logic [DW-1:0] exp_q[$];
  string         tag_q[$];
  logic          rd_pend = 1'b0;
  bit            done = 1'b0;

  always #4 clk = ~clk;

  accel_ctrl_regs #(.AW(AW), .DW(DW), .NDOM(4), .PRESENT(PRES)) u_accel_ctrl_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq(irq), .reset_pulse(reset_pulse)
  );

  // monitor: one read result per sampled rd_en
  always @(posedge clk) rd_pend <= rd_en;
  always @(negedge clk) begin
    if (rd_pend && exp_q.size() > 0) begin
      logic [DW-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      compared++;
      if (rd_data !== e) begin
        mismatched++;
        $display("FAIL %s read: actual %h expected %h", t, rd_data, e);
      end
    end
  end

  task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string t);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, input logic [DW-1:0] e, input string t);
    rd_en = 1'b1; rd_addr = AW'(a);
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(DW'(irq), 0, "R1 irq");
    chk(DW'(reset_pulse), 0, "R1 reset_pulse");
    rd(8'h12, 0, "R1 shader ready lo");
    rd(8'h2B, 0, "R1 l3 ready hi");
    rd(1, 0, "R1 raw");
    rd(3, 0, "R1 mask");
    // R11 present and unmapped reads
    rd(8'h10, 32'hFF, "R11 shader present lo");
    rd(8'h11, 32'hF, "R11 shader present hi");
    rd(8'h14, 0, "R11 power word reads zero");
    rd(8'h07, 0, "R11 unmapped");
    // R2 power on, masked by present
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h12, 32'hFF, "R2 shader ready lo");
    rd(1, 32'h6, "R4 raw after power on");
    wr(8'h15, 32'h0000_0013);
    rd(8'h13, 32'h3, "R2 shader ready hi");
    wr(8'h2C, 32'hFFFF);
    rd(8'h2A, 0, "R2 l3 absent stays zero");
    wr(2, 32'h1F);
    rd(1, 0, "R8 clear all");
    wr(8'h2C, 32'h1);
    rd(1, 32'h6, "R4 event without ready change");
    wr(2, 32'h2);
    rd(1, 32'h4, "R8 partial clear");
    wr(2, 32'h4);
    // R3 power off
    wr(8'h16, 32'h0F);
    rd(8'h12, 32'hF0, "R3 shader ready lo");
    rd(1, 32'h6, "R4 raw after power off");
    wr(8'h17, 32'h1);
    rd(8'h13, 32'h2, "R3 shader ready hi");
    // R9 status and irq
    chk(DW'(irq), 0, "R9 irq low while masked");
    wr(3, 32'h4);
    rd(4, 32'h4, "R9 status");
    chk(DW'(irq), 1, "R9 irq high");
    wr(2, 32'h6);
    @(negedge clk);
    chk(DW'(irq), 0, "R9 irq low after clear");
    rd(4, 0, "R9 status cleared");
    wr(3, 32'h0);
    // R6 completion commands
    wr(0, 4);
    chk(DW'(reset_pulse), 0, "R6 no pulse on sample");
    rd(1, 32'h8, "R6 sample done");
    wr(0, 7);
    rd(1, 32'h18, "R6 clean done");
    wr(2, 32'h1F);
    wr(0, 8);
    rd(1, 32'h10, "R6 clean-invalidate done");
    wr(2, 32'h1F);
    // R7 no-effect commands
    wr(0, 0); wr(0, 3); wr(0, 5); wr(0, 6);
    wr(0, 9); wr(0, 15); wr(0, 32'hFFFF_FFFF); wr(0, 32'h0000_0101);
    chk(DW'(reset_pulse), 0, "R7 no pulse");
    rd(1, 0, "R7 raw untouched");
    rd(8'h12, 32'hF0, "R7 ready untouched");
    // R10 ignored writes
    wr(8'h12, 32'hFFFF_FFFF); wr(8'h10, 0); wr(1, 32'h1F);
    wr(4, 32'h1F); wr(8'h3F, 32'h1F); wr(8'h06, 32'h1F);
    rd(8'h12, 32'hF0, "R10 ready untouched");
    rd(8'h10, 32'hFF, "R10 present untouched");
    rd(1, 0, "R10 raw untouched");
    rd(3, 0, "R10 mask untouched");
    // R5 soft reset with live state
    wr(3, 32'h1F);
    wr(0, 1);
    chk(DW'(reset_pulse), 1, "R5 pulse soft");
    @(negedge clk);
    chk(DW'(reset_pulse), 0, "R5 pulse one cycle");
    chk(DW'(irq), 0, "R5 irq off, mask cleared");
    rd(1, 32'h1, "R5 raw soft");
    rd(3, 0, "R5 mask soft");
    rd(8'h12, 0, "R5 ready lo soft");
    rd(8'h13, 0, "R5 ready hi soft");
    // R5 hard reset
    wr(8'h1C, 32'h1);
    wr(8'h14, 32'h3);
    wr(3, 32'h6);
    wr(0, 2);
    chk(DW'(reset_pulse), 1, "R5 pulse hard");
    rd(1, 32'h1, "R5 raw hard");
    rd(8'h1A, 0, "R5 tiler ready hard");
    rd(8'h12, 0, "R5 shader ready hard");
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule